// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a register-programmed SPI master. Software sets the word length, the number of words in a block, the clock idle level and phase, and how the chip selects behave. A write with the start bit set then runs the whole block with no further software help. The engine takes each outgoing word from a simple word source, which has a valid flag and a pop strobe. It returns each received word to a word sink through a one-cycle push strobe. FIFOs and DMA sit outside the block.

The serial clock always runs at a quarter of the module clock. Each bit uses four module-clock cycles. One extra load cycle sits between words, and in that cycle the serial clock rests at its idle level. Transmit and receive can each be switched off, so a block can run in one direction only. One of four chip selects is driven. Each select has its own polarity bit. A select is asserted either for the length of the block or directly by a software bit, so it can be held across several blocks.

Top module: `spi_eng`

## Requirements
- R1: Control word 0 bits [4:0] hold the bits per word minus one (1 to 32 bits). Bits go out on `mosi_o` most significant first, taken from bit n-1 down to bit 0 of the source word. The received word carries the n sampled bits in its low positions, with the first bit received as its most significant bit, and zeros above them.
- R2: Control word 1 bits [15:0] hold the number of words minus one. Exactly that many words are popped when transmit is on, and pushed when receive is on.
- R3: The serial clock is the module clock divided by four. With no stall, a block of W words of n bits keeps busy high for exactly W*(4n+1) cycles.
- R4: Control word 0 bit 6 sets the idle level of `sclk_o` (0 low, 1 high), and the clock sits at that level whenever no bit is being shifted. Control word 0 bit 5 sets the phase: with 0, `miso_i` is sampled on the first clock edge of each bit; with 1, on the second edge.
- R5: Control word 0 bits [9:8] pick the chip select, and bits [13:10] give one polarity bit per select (1 means active high). In automatic mode the picked select is active while busy, and every other select stays at its inactive level.
- R6: When control word 0 bit 14 is 1, the picked select follows control word 0 bit 15 (1 means asserted), before, during and after a block.
- R7: When control word 1 bit 16 (transmit enable) is 0, no word is popped and `mosi_o` stays at 0.
- R8: When control word 1 bit 17 (receive enable) is 0, no word is pushed.
- R9: Registers are addressed as 0 (control word 0), 1 (control word 1) and 2 (status). Writing control word 0 with bit 31 set starts a block. Status bit 0 is busy. Status bit 1 (ready) sets on the same edge at which busy falls.
- R10: Writing status with bit 1 set clears ready. Writing 0 there leaves ready unchanged.
- R11: If the source is empty when a word is needed, the engine waits with busy high, `sclk_o` at idle and the chip select still asserted, then resumes once data arrives.
- R12: `irq_o` is high exactly when ready is set and control word 1 bit 18 is 1.
- R13: After reset, every chip select is high, `sclk_o`, `mosi_o`, `irq_o` and both strobes are low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| tx_valid_i | input | 1 | Word source holds a word |
| tx_data_i | input | 32 | Word at the head of the source |
| tx_pop_o | output | 1 | Take the head word |
| rx_push_o | output | 1 | Received word valid, one cycle |
| rx_data_o | output | 32 | Received word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip selects, per-select polarity |
| irq_o | output | 1 | Completion interrupt, level |

## Verification
If the bit counter or the phase counter is wrong, `sclk_o` shows the wrong number of edges per word, and the very next word seen on `mosi_o`, or the length of busy, is off at once. A sample point on the wrong clock edge picks up the slave's next bit, so the first received word is already shifted by one bit. The bench slave changes `miso_i` right at the correct sample edge to expose this. If the word counter or the ready state is wrong, busy ends early or late and ready, `irq_o` and the queues do not line up at the end of the block. A bad select decode shows on `cs_o` in the first busy cycle.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [1:0] ADDR_CTRL0 = 2'd0;
  localparam logic [1:0] ADDR_CTRL1 = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

  // control word 0 fields
  localparam int F_CPHA = 5;
  localparam int F_IDLE = 6;
  localparam int F_SEL  = 8;
  localparam int F_POL  = 10;
  localparam int F_SW   = 14;
  localparam int F_VAL  = 15;
  localparam int F_GO   = 31;
  // control word 1 fields
  localparam int F_TXEN  = 16;
  localparam int F_RXEN  = 17;
  localparam int F_IRQEN = 18;
  // status fields
  localparam int F_BUSY = 0;
  localparam int F_RDY  = 1;

  localparam logic [31:0] CTRL0_MASK = 32'h0000_FFFF;
  localparam logic [31:0] CTRL1_MASK = 32'h0007_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} eng_state_e;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 5,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic              cpha_o,
  output logic              idle_hi_o,
  output logic [SEL_W-1:0]  cs_sel_o,
  output logic [NUM_CS-1:0] cs_pol_o,
  output logic              cs_sw_o,
  output logic              cs_val_o,
  output logic [CNT_W-1:0]  blk_m1_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              go_o,
  output logic              ready_o,
  output logic              irq_o
);
  logic [31:0] ctrl0_q, ctrl1_q;
  logic        ready_q;

  wire wr0   = we_i && (addr_i == ADDR_CTRL0);
  wire wr1   = we_i && (addr_i == ADDR_CTRL1);
  wire clr_r = we_i && (addr_i == ADDR_STAT) && wdata_i[F_RDY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (wr0) ctrl0_q <= wdata_i & CTRL0_MASK;
      if (wr1) ctrl1_q <= wdata_i & CTRL1_MASK;
      if (done_i)     ready_q <= 1'b1;   // completion wins over a clear
      else if (clr_r) ready_q <= 1'b0;
    end
  end

  assign go_o      = wr0 && wdata_i[F_GO] && !busy_i;
  assign len_m1_o  = ctrl0_q[LEN_W-1:0];
  assign cpha_o    = ctrl0_q[F_CPHA];
  assign idle_hi_o = ctrl0_q[F_IDLE];
  assign cs_sel_o  = ctrl0_q[F_SEL +: SEL_W];
  assign cs_pol_o  = ctrl0_q[F_POL +: NUM_CS];
  assign cs_sw_o   = ctrl0_q[F_SW];
  assign cs_val_o  = ctrl0_q[F_VAL];
  assign blk_m1_o  = ctrl1_q[CNT_W-1:0];
  assign tx_en_o   = ctrl1_q[F_TXEN];
  assign rx_en_o   = ctrl1_q[F_RXEN];
  assign ready_o   = ready_q;
  assign irq_o     = ready_q && ctrl1_q[F_IRQEN];

  always_comb begin
    case (addr_i)
      ADDR_CTRL0: rdata_o = ctrl0_q;
      ADDR_CTRL1: rdata_o = ctrl1_q;
      ADDR_STAT: begin
        rdata_o         = '0;
        rdata_o[F_BUSY] = busy_i;
        rdata_o[F_RDY]  = ready_q;
      end
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_eng_core.sv
module spi_eng_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              cpha_i,
  input  logic              idle_hi_i,
  input  logic [CNT_W-1:0]  blk_m1_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o
);
  eng_state_e        st_q;
  logic [1:0]        ph_q;
  logic [LEN_W-1:0]  bit_q;
  logic [CNT_W-1:0]  word_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;

  wire shifting = (st_q == ST_SHIFT);
  // sample point: first edge (end of ph 1) or second edge (end of ph 2)
  wire samp     = shifting && (ph_q == (cpha_i ? 2'd2 : 2'd1));
  wire word_end = shifting && (ph_q == 2'd3) && (bit_q == '0);
  wire load_ok  = (st_q == ST_LOAD) && (!tx_en_i || tx_valid_i);
  wire sclk_act = cpha_i ? (ph_q == 2'd1 || ph_q == 2'd2) : ph_q[1];

  assign done_o   = word_end && (word_q == blk_m1_i);
  assign tx_pop_o = (st_q == ST_LOAD) && tx_en_i && tx_valid_i;
  assign busy_o   = (st_q != ST_IDLE);
  assign sclk_o   = idle_hi_i ^ (shifting && sclk_act);
  assign mosi_o   = shifting && tx_sh_q[bit_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ph_q      <= '0;
      bit_q     <= '0;
      word_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      rx_push_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_q   <= ST_LOAD;
          word_q <= '0;
        end
        ST_LOAD: if (load_ok) begin
          tx_sh_q <= tx_en_i ? tx_data_i : '0;
          rx_sh_q <= '0;
          bit_q   <= len_m1_i;
          ph_q    <= '0;
          st_q    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          ph_q <= ph_q + 2'd1;
          if (samp) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
          if (ph_q == 2'd3) begin
            if (bit_q != '0) begin
              bit_q <= bit_q - 1'b1;
            end else begin
              if (rx_en_i) begin
                rx_push_o <= 1'b1;
                rx_data_o <= rx_sh_q;
              end
              if (word_q == blk_m1_i) begin
                st_q <= ST_IDLE;
              end else begin
                word_q <= word_q + 1'b1;
                st_q   <= ST_LOAD;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eng_cs.sv
module spi_eng_cs #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_CS-1:0] pol_i,
  input  logic              sw_i,
  input  logic              val_i,
  input  logic              busy_i,
  output logic [NUM_CS-1:0] cs_o
);
  wire assert_now = sw_i ? val_i : busy_i;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    wire act = assert_now && (sel_i == SEL_W'(i));
    assign cs_o[i] = act ? pol_i[i] : ~pol_i[i];
  end
endmodule

// File: rtl/spi_eng.sv
module spi_eng
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              irq_o
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int SEL_W = $clog2(NUM_CS);

  logic [LEN_W-1:0]  len_m1;
  logic              cpha, idle_hi, cs_sw, cs_val, tx_en, rx_en;
  logic [SEL_W-1:0]  cs_sel;
  logic [NUM_CS-1:0] cs_pol;
  logic [CNT_W-1:0]  blk_m1;
  logic              go, busy, done, ready;

  spi_eng_regs #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done),
    .len_m1_o(len_m1), .cpha_o(cpha), .idle_hi_o(idle_hi),
    .cs_sel_o(cs_sel), .cs_pol_o(cs_pol), .cs_sw_o(cs_sw), .cs_val_o(cs_val),
    .blk_m1_o(blk_m1), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .go_o(go), .ready_o(ready), .irq_o(irq_o)
  );

  spi_eng_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .go_i(go), .len_m1_i(len_m1), .cpha_i(cpha), .idle_hi_i(idle_hi),
    .blk_m1_i(blk_m1), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_valid_i, .tx_data_i, .tx_pop_o,
    .rx_push_o, .rx_data_o,
    .miso_i, .sclk_o, .mosi_o,
    .busy_o(busy), .done_o(done)
  );

  spi_eng_cs #(.NUM_CS(NUM_CS)) u_cs (
    .sel_i(cs_sel), .pol_i(cs_pol), .sw_i(cs_sw), .val_i(cs_val),
    .busy_i(busy), .cs_o
  );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              ready,
  input logic              idle_hi,
  input logic              tx_en,
  input logic              rx_en,
  input logic              cs_sw,
  input logic [NUM_CS-1:0] cs_pol,
  input logic [NUM_CS-1:0] cs_o,
  input logic              tx_pop_o,
  input logic              rx_push_o,
  input logic              sclk_o,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic              clr_bit
);
  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o == idle_hi));

  p_cs_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ ~cs_pol) <= 1);

  p_cs_auto_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_sw && !busy) |-> (cs_o == ~cs_pol));

  p_pop_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> (tx_en && busy));

  p_push_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> rx_en);

  p_ready_at_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> ready);

  p_ready_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !(reg_we_i && reg_addr_i == ADDR_STAT && clr_bit)) |=> ready);
endmodule

bind spi_eng spi_eng_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .ready(ready), .idle_hi(idle_hi),
  .tx_en(tx_en), .rx_en(rx_en), .cs_sw(cs_sw), .cs_pol(cs_pol), .cs_o(cs_o),
  .tx_pop_o(tx_pop_o), .rx_push_o(rx_push_o), .sclk_o(sclk_o),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .clr_bit(reg_wdata_i[1])
);

// File: tb/spi_eng_bench.sv
module spi_eng_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_push, sclk, mosi, irq;
  logic        miso = 1'b0;
  logic [31:0] rx_data;
  logic [3:0]  cs;

  always #5 clk = ~clk;

  spi_eng u_spi_eng (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_o(cs), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  int pop_cnt = 0, push_cnt = 0;
  logic [31:0] src_q[$], exp_mosi_q[$], exp_rx_q[$], slave_q[$];
  logic pop_d = 1'b0;
  bit   in_xfer = 0, cfg_cpha = 0, cfg_idle = 0;
  int   cfg_bits = 8;
  logic [31:0] slave_word = '0, mon_w = '0;
  int   slave_idx = 0, mon_n = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int b);
    return (b >= 32) ? 32'hFFFF_FFFF : ((32'h1 << b) - 32'h1);
  endfunction

  // word source model
  always @(posedge clk) pop_d <= tx_pop;
  always @(negedge clk) begin
    if (pop_d) begin
      if (src_q.size() > 0) void'(src_q.pop_front());
      pop_cnt++;
    end
    tx_valid = (src_q.size() != 0);
    tx_data  = (src_q.size() != 0) ? src_q[0] : 32'h0;
  end

  // receive monitor: compare pushed words to the scoreboard
  always @(negedge clk) begin
    if (rx_push) begin
      push_cnt++;
      if (exp_rx_q.size() == 0) chk(0, "R8 unexpected rx push", rx_data, 0);
      else begin
        logic [31:0] e;
        e = exp_rx_q.pop_front();
        chk(rx_data === e, "R1 rx word", rx_data, e);
      end
    end
  end

  // bus monitor and slave: act on the sample edge of sclk
  always @(sclk) begin
    if (in_xfer && (cfg_cpha ? (sclk == cfg_idle) : (sclk != cfg_idle))) begin
      mon_w = {mon_w[30:0], mosi};
      mon_n++;
      if (mon_n == cfg_bits) begin
        if (exp_mosi_q.size() == 0) chk(0, "R2 extra mosi word", mon_w, 0);
        else begin
          logic [31:0] e;
          e = exp_mosi_q.pop_front();
          chk((mon_w & msk(cfg_bits)) === e, "R1 mosi word", mon_w & msk(cfg_bits), e);
        end
        mon_n = 0;
        mon_w = '0;
      end
      #1;
      slave_idx--;
      if (slave_idx < 0) begin
        slave_word = (slave_q.size() > 0) ? slave_q.pop_front() : 32'h0;
        slave_idx  = cfg_bits - 1;
      end
      miso = slave_word[slave_idx];
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
    reg_addr  = 2'd2;
    reg_wdata = '0;
  endtask

  task automatic run(input int bits, input int words, input bit cpha, input bit idle,
                     input int sel, input logic [3:0] pol, input bit txen, input bit rxen,
                     input bit irqen, input bit sw, input bit stall, input logic [31:0] seed);
    logic [31:0] c0, c1, tw, sv, m;
    logic [3:0]  act_cs, off_cs;
    logic [31:0] held[$];
    int cnt, pop0, push0;
    bit cs_bad;
    m = msk(bits);
    cfg_bits = bits; cfg_cpha = cpha; cfg_idle = idle;
    c1 = 32'(words - 1) | (32'(txen) << 16) | (32'(rxen) << 17) | (32'(irqen) << 18);
    c0 = 32'(bits - 1) | (32'(cpha) << 5) | (32'(idle) << 6) | (32'(sel) << 8)
       | (32'(pol) << 10) | (32'(sw) << 14) | (32'(sw) << 15);
    off_cs = ~pol;
    act_cs = off_cs;
    act_cs[sel] = pol[sel];
    wr(2'd1, c1);
    wr(2'd0, c0);
    for (int k = 0; k < words; k++) begin
      tw = (32'h9E37_79B9 * 32'(k + 1)) ^ (seed << 8);
      sv = (32'h5BD1_E995 * 32'(k + 3)) ^ seed;
      if (txen) begin
        if (stall && k > 0) held.push_back(tw);
        else src_q.push_back(tw);
      end
      exp_mosi_q.push_back(txen ? (tw & m) : 32'h0);
      slave_q.push_back(sv);
      if (rxen) exp_rx_q.push_back(sv & m);
    end
    slave_word = slave_q.pop_front();
    slave_idx  = bits - 1;
    miso       = slave_word[slave_idx];
    mon_n = 0; mon_w = '0;
    in_xfer = 1;
    @(negedge clk); @(negedge clk);
    chk(sclk === idle, "R4 sclk idle level before start", 32'(sclk), 32'(idle));
    if (sw) chk(cs === act_cs, "R6 software select asserted before start", 32'(cs), 32'(act_cs));
    else    chk(cs === off_cs, "R5 selects inactive before start", 32'(cs), 32'(off_cs));
    pop0 = pop_cnt; push0 = push_cnt;
    wr(2'd0, c0 | 32'h8000_0000);
    #1;
    cnt = 0; cs_bad = 0;
    while (reg_rdata[0]) begin
      cnt++;
      if (cs !== act_cs) cs_bad = 1;
      if (stall && cnt == 60) begin
        chk(sclk === idle, "R11 sclk idle while source empty", 32'(sclk), 32'(idle));
        chk(pop_cnt - pop0 == 1, "R11 one word taken before stall", 32'(pop_cnt - pop0), 1);
        chk(cs === act_cs, "R11 select held during stall", 32'(cs), 32'(act_cs));
        while (held.size() > 0) src_q.push_back(held.pop_front());
      end
      @(negedge clk); #1;
    end
    chk(reg_rdata[1] === 1'b1, "R9 ready set when busy falls", reg_rdata, 32'h2);
    chk(irq === irqen, "R12 irq follows ready and enable", 32'(irq), 32'(irqen));
    if (!stall) chk(cnt == words * (4 * bits + 1), "R3 busy duration", 32'(cnt), 32'(words * (4 * bits + 1)));
    chk(!cs_bad, sw ? "R6 select during block" : "R5 select during block", 32'(cs_bad), 0);
    @(negedge clk); @(negedge clk);
    chk(exp_mosi_q.size() == 0, "R2 all mosi words seen", 32'(exp_mosi_q.size()), 0);
    if (rxen) chk(push_cnt - push0 == words, "R2 push count", 32'(push_cnt - push0), 32'(words));
    else      chk(push_cnt == push0, "R8 no push with receive off", 32'(push_cnt - push0), 0);
    if (txen) chk(pop_cnt - pop0 == words, "R2 pop count", 32'(pop_cnt - pop0), 32'(words));
    else      chk(pop_cnt == pop0, "R7 no pop with transmit off", 32'(pop_cnt - pop0), 0);
    if (sw) chk(cs === act_cs, "R6 select held after block", 32'(cs), 32'(act_cs));
    else    chk(cs === off_cs, "R5 select released after block", 32'(cs), 32'(off_cs));
    in_xfer = 0;
    if (irqen) begin
      wr(2'd2, 32'h0);
      #1;
      chk(reg_rdata[1] === 1'b1 && irq === 1'b1, "R10 writing zero keeps ready", reg_rdata, 32'h2);
      wr(2'd2, 32'h2);
      #1;
      chk(reg_rdata[1] === 1'b0 && irq === 1'b0, "R10 R12 write one clears ready and irq", reg_rdata, 32'h0);
    end else begin
      wr(2'd2, 32'h2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cs === 4'hF, "R13 selects high in reset", 32'(cs), 32'hF);
    chk({sclk, mosi, irq, tx_pop, rx_push} === 5'b0, "R13 outputs low in reset",
        32'({sclk, mosi, irq, tx_pop, rx_push}), 0);
    chk(reg_rdata === 32'h0, "R13 status zero in reset", reg_rdata, 0);
    rst_n = 1'b1;
    run(8, 3, 0, 0, 0, 4'b0000, 1, 1, 1, 0, 0, 32'h11);
    run(12, 2, 1, 1, 2, 4'b0100, 1, 1, 0, 0, 0, 32'h22);
    run(32, 1, 1, 0, 3, 4'b0000, 1, 1, 0, 0, 0, 32'h33);
    run(1, 4, 0, 1, 1, 4'b1111, 1, 1, 0, 0, 0, 32'h44);
    run(8, 2, 0, 0, 0, 4'b0000, 1, 0, 0, 0, 0, 32'h55);
    run(16, 2, 1, 0, 1, 4'b0000, 0, 1, 0, 0, 0, 32'h66);
    run(8, 1, 0, 0, 1, 4'b0000, 1, 1, 0, 1, 0, 32'h77);
    wr(2'd0, 32'h0000_4107);   // software mode, value 0, select 1
    #1;
    chk(cs === 4'hF, "R6 software value 0 releases select", 32'(cs), 32'hF);
    run(8, 3, 0, 0, 0, 4'b0000, 1, 1, 0, 0, 1, 32'h88);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule